// File: doc/BRIEF.md
# Clock Output Power-Management Controller

This block is the control logic of a multi-output clock generator. It decides, cycle by cycle, whether each of a set of differential clock pairs and one single-ended reference output runs, is held low or floats. It looks at a combined power-good/power-down pin, per-pair active-low enable pins, per-pair register enable bits and a PLL lock flag. The first time the power-good pin goes high, the block captures two configuration straps: a tri-level spread-amount select and a bus-address select. It then holds them until reset.

All asynchronous pins (power-good, lock and the pair enable pins) pass through a multi-flop synchroniser into the source clock domain. Each differential pair is modelled as a half-rate clock built from a free-running phase register. The true leg follows the phase and the complement follows its inverse. A pair's open/closed gate may change only on the edge where the true leg goes low, so a pulse is never cut short. The spread select, the bus address and the reference drive state go to the synthesis, serial-bus and pad logic, which are outside this block.

Top module: `clkout_pm_ctrl`

## Requirements
- R1: The straps are captured only on the first high level of the synchronised power-good input after reset. Later power-good rises leave the captured spread select and bus address unchanged, even if the strap inputs have changed.
- R2: The 2-bit spread strap code maps as follows: 00 gives `spreadSel` 00 (no spread), 01 gives 01 (-0.25%), and 10 or 11 give 10 (-0.5%). Before capture, `spreadSel` reads 00.
- R3: The bus address is 7'b1101000 when the address strap is 0 and 7'b1101010 when it is 1. Before capture, it reads 7'b1101000.
- R4: While power-good is low, every pair drives both `difTrue` and `difComp` low.
- R5: `refDrive` is 2'b10 (high-impedance) from reset until the first power-good high. It is 2'b01 (running) while power-good is high, and 2'b00 (driven low) during any later power-down.
- R6: With power-good high and lock qualified, pair i runs only when `regEn[i]`=1 and `oeN[i]`=0. Otherwise both of its legs are low, and `refDrive` stays 2'b01 either way.
- R7: A running pair toggles its true leg on every source clock edge, with the complement as its exact inverse. The true and complement legs are never high together.
- R8: All pairs stay low until the synchronised lock flag has been seen high while powered up.
- R9: A power-down clears the lock qualification. After power-good returns, the pairs stay low until lock is seen again.
- R10: A gate change takes effect only at the edge where the true leg goes low. The true leg of a pair never rises directly from a state where both legs were low; the complement leg leads after an enable.
- R11: After reset, all legs are low, `refDrive` is 2'b10, `spreadSel` is 00 and `busAddr` is 7'b1101000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pllLock | input | 1 | PLL lock flag, asynchronous |
| pwrGood | input | 1 | Power-good (high) / power-down (low) pin, asynchronous |
| oeN | input | NUM_PAIRS | Per-pair active-low enable pins, asynchronous |
| regEn | input | NUM_PAIRS | Per-pair register enable bits, synchronous to clk |
| spreadStrap | input | 2 | Pre-encoded tri-level spread strap |
| addrStrap | input | 1 | Bus-address strap |
| difTrue | output | NUM_PAIRS | True leg of each differential pair |
| difComp | output | NUM_PAIRS | Complement leg of each differential pair |
| refDrive | output | 2 | Reference output state: 00 low, 01 running, 10 high-impedance |
| spreadSel | output | 2 | Captured spread setting |
| busAddr | output | 7 | Captured 7-bit bus address |

## Verification
The bench builds the block with its defaults: eight pairs and a two-flop synchroniser. With eight pairs, a single stimulus vector can mix enabled pairs, pin-disabled pairs and register-disabled pairs. With the two-stage depth, the settle time before each observation stays short, so the bench can step through several power-down/lock sequences. These include a power-down exit with lock absent, and a change of the strap inputs between power-good rises. Further resets with different strap codes reach the 11 spread code and both address values.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    REF_LOW = 2'b00,
    REF_RUN = 2'b01,
    REF_HIZ = 2'b10
  } ref_drive_e;

  typedef enum logic [1:0] {
    SPR_OFF     = 2'b00,
    SPR_QUARTER = 2'b01,
    SPR_HALF    = 2'b10
  } spread_e;

  typedef enum logic [1:0] {
    PM_COLD = 2'b00,
    PM_RUN  = 2'b01,
    PM_DOWN = 2'b10
  } pm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;     // powered up
    logic lockOk;  // lock qualified since last power-up
  } ctl_strobe_t;

  function automatic spread_e decodeSpread(input logic [1:0] code);
    case (code)
      2'b00:   return SPR_OFF;
      2'b01:   return SPR_QUARTER;
      default: return SPR_HALF;
    endcase
  endfunction

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else if (s == 0) chain[s] <= asyncIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter logic [6:0] ADDR_LO = 7'b1101000,
  parameter logic [6:0] ADDR_HI = 7'b1101010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pgSync,
  input  logic        lockSync,
  input  logic [1:0]  spreadStrap,
  input  logic        addrStrap,
  output ctl_strobe_t ctl,
  output ref_drive_e  refDrive,
  output spread_e     spreadSel,
  output logic [6:0]  busAddr
);

  pm_state_e state, stateNext;
  logic      lockSeen;
  logic      captureStraps;

  assign captureStraps = (state == PM_COLD) && pgSync;

  always_comb begin
    stateNext = state;
    case (state)
      PM_COLD: if (pgSync)  stateNext = PM_RUN;
      PM_RUN:  if (!pgSync) stateNext = PM_DOWN;
      PM_DOWN: if (pgSync)  stateNext = PM_RUN;
      default: stateNext = PM_COLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PM_COLD;
      spreadSel <= SPR_OFF;
      busAddr   <= ADDR_LO;
      lockSeen  <= 1'b0;
    end else begin
      state <= stateNext;
      if (captureStraps) begin
        spreadSel <= decodeSpread(spreadStrap);
        busAddr   <= addrStrap ? ADDR_HI : ADDR_LO;
      end
      if (state != PM_RUN) lockSeen <= 1'b0;
      else if (lockSync)   lockSeen <= 1'b1;
    end
  end

  always_comb begin
    case (state)
      PM_RUN:  refDrive = REF_RUN;
      PM_DOWN: refDrive = REF_LOW;
      default: refDrive = REF_HIZ;
    endcase
  end

  assign ctl.run    = (state == PM_RUN);
  assign ctl.lockOk = lockSeen;

  // R1: once out of the cold state, captured straps never move
  a_r1_straps_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state != PM_COLD && $past(state) != PM_COLD) |-> ($stable(spreadSel) && $stable(busAddr)));

  // R5: after a powered-up cycle the reference never floats again
  a_r5_no_float_after_up: assert property (@(posedge clk) disable iff (!rstN)
    $past(state == PM_RUN) |-> (refDrive != REF_HIZ));

  // R9: a settled power-down leaves no lock qualification behind
  a_r9_lock_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_DOWN && $past(state) == PM_DOWN) |-> !lockSeen);

endmodule

// File: rtl/clkpm_dpath.sv
module clkpm_dpath
  import clkpm_pkg::*;
#(
  parameter int NUM_PAIRS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          ctl,
  input  logic [NUM_PAIRS-1:0] regEn,
  input  logic [NUM_PAIRS-1:0] oeSync,
  output logic [NUM_PAIRS-1:0] difTrue,
  output logic [NUM_PAIRS-1:0] difComp
);

  logic                 phase;
  logic [NUM_PAIRS-1:0] gate;
  logic                 openAllowed;

  assign openAllowed = ctl.run && ctl.lockOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  generate
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      logic want;
      assign want = openAllowed && regEn[i] && !oeSync[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             gate[i] <= 1'b0;
        else if (!openAllowed) gate[i] <= 1'b0;
        else if (phase)        gate[i] <= want;
      end

      assign difTrue[i] = phase & gate[i];
      assign difComp[i] = ~phase & gate[i];
    end
  endgenerate

  // R7: legs never high together
  a_r7_legs_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (difTrue & difComp) == '0);

  // R8: without qualified lock every gate is shut on the next edge
  a_r8_blocked_until_lock: assert property (@(posedge clk) disable iff (!rstN)
    !openAllowed |=> (gate == '0));

  // R10: a qualified gate change only lands when the true leg drops
  a_r10_low_phase_only: assert property (@(posedge clk) disable iff (!rstN)
    ((gate != $past(gate)) && $past(openAllowed)) |-> $past(phase));

endmodule

// File: rtl/clkout_pm_ctrl.sv
module clkout_pm_ctrl
  import clkpm_pkg::*;
#(
  parameter int         NUM_PAIRS   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'b1101000,
  parameter logic [6:0] ADDR_HI     = 7'b1101010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pllLock,
  input  logic                 pwrGood,
  input  logic [NUM_PAIRS-1:0] oeN,
  input  logic [NUM_PAIRS-1:0] regEn,
  input  logic [1:0]           spreadStrap,
  input  logic                 addrStrap,
  output logic [NUM_PAIRS-1:0] difTrue,
  output logic [NUM_PAIRS-1:0] difComp,
  output logic [1:0]           refDrive,
  output logic [1:0]           spreadSel,
  output logic [6:0]           busAddr
);

  localparam int SYNC_W = NUM_PAIRS + 2;

  logic [SYNC_W-1:0]    syncBus;
  logic                 pgSync, lockSync;
  logic [NUM_PAIRS-1:0] oeSync;
  ctl_strobe_t          ctl;
  ref_drive_e           refState;
  spread_e              spreadState;

  clkpm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({pwrGood, pllLock, oeN}),
    .syncOut (syncBus)
  );

  assign {pgSync, lockSync, oeSync} = syncBus;

  clkpm_ctrl #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .pgSync      (pgSync),
    .lockSync    (lockSync),
    .spreadStrap (spreadStrap),
    .addrStrap   (addrStrap),
    .ctl         (ctl),
    .refDrive    (refState),
    .spreadSel   (spreadState),
    .busAddr     (busAddr)
  );

  clkpm_dpath #(.NUM_PAIRS(NUM_PAIRS)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .regEn   (regEn),
    .oeSync  (oeSync),
    .difTrue (difTrue),
    .difComp (difComp)
  );

  assign refDrive  = refState;
  assign spreadSel = spreadState;

endmodule

// File: tb/clkout_pm_ctrl_tb_top.sv
module clkout_pm_ctrl_tb_top;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pllLock = 1'b0;
  logic          pwrGood = 1'b0;
  logic [NP-1:0] oeN = '0;
  logic [NP-1:0] regEn = '1;
  logic [1:0]    spreadStrap = 2'b00;
  logic          addrStrap = 1'b0;
  logic [NP-1:0] difTrue, difComp;
  logic [1:0]    refDrive, spreadSel;
  logic [6:0]    busAddr;

  always #5 clk = ~clk;

  clkout_pm_ctrl #(.NUM_PAIRS(NP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .pllLock(pllLock), .pwrGood(pwrGood),
    .oeN(oeN), .regEn(regEn), .spreadStrap(spreadStrap), .addrStrap(addrStrap),
    .difTrue(difTrue), .difComp(difComp), .refDrive(refDrive),
    .spreadSel(spreadSel), .busAddr(busAddr)
  );

  typedef struct {
    logic [NP-1:0] mask;
    logic [1:0]    refExp;
    logic [1:0]    sprExp;
    logic [6:0]    addrExp;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails = 0;
  int   issued = 0;
  int   consumed = 0;
  int   runtHits = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // driver: let the stimulus settle, then queue what must be seen
  task automatic expect_state(input logic [NP-1:0] mask, input logic [1:0] r,
                              input logic [1:0] s, input logic [6:0] a, input string tag);
    exp_t e;
    repeat (14) @(negedge clk);
    e.mask = mask; e.refExp = r; e.sprExp = s; e.addrExp = a; e.tag = tag;
    expQ.push_back(e);
    issued++;
    wait (consumed == issued);
  endtask

  task automatic do_reset(input logic [1:0] spr, input logic adr);
    @(negedge clk);
    rstN = 1'b0; pwrGood = 1'b0; pllLock = 1'b0;
    spreadStrap = spr; addrStrap = adr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor: pop an item, watch four cycles, compare
  initial begin
    forever begin
      exp_t e;
      logic [NP-1:0] tS [4];
      logic [NP-1:0] cS [4];
      logic [NP-1:0] obsRun, obsLow;
      while (expQ.size() == 0) @(negedge clk);
      e = expQ.pop_front();
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        tS[k] = difTrue; cS[k] = difComp;
      end
      for (int i = 0; i < NP; i++) begin
        obsRun[i] = 1'b1; obsLow[i] = 1'b1;
        for (int k = 0; k < 4; k++) begin
          if (cS[k][i] != ~tS[k][i]) obsRun[i] = 1'b0;
          if (k > 0 && tS[k][i] == tS[k-1][i]) obsRun[i] = 1'b0;
          if (tS[k][i] || cS[k][i]) obsLow[i] = 1'b0;
        end
      end
      chk(obsRun == e.mask && obsLow == ~e.mask, e.tag, "pair run mask (R7 toggle)",
          int'(obsRun), int'(e.mask));
      chk(refDrive == e.refExp, e.tag, "refDrive", int'(refDrive), int'(e.refExp));
      chk(spreadSel == e.sprExp, e.tag, "spreadSel", int'(spreadSel), int'(e.sprExp));
      chk(busAddr == e.addrExp, e.tag, "busAddr", int'(busAddr), int'(e.addrExp));
      consumed++;
    end
  end

  // R10 watcher: a true leg must never rise out of a fully-low state
  initial begin
    logic [NP-1:0] pT = '0, pC = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        for (int i = 0; i < NP; i++)
          if (difTrue[i] && !pT[i] && !pC[i]) runtHits++;
      end
      pT = difTrue; pC = difComp;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    do_reset(2'b01, 1'b1);
    // R11 reset state, R5 floating reference
    expect_state('0, 2'b10, 2'b00, 7'b1101000, "R11");
    // R4: lock and enables present, but no power-good
    pllLock = 1'b1;
    expect_state('0, 2'b10, 2'b00, 7'b1101000, "R4");
    // R1 R2 R3 first power-good captures 01 and address 1
    pwrGood = 1'b1;
    expect_state(8'hFF, 2'b01, 2'b01, 7'b1101010, "R1_R2_R3");
    // R6 pin disables, straps moved but not recaptured
    spreadStrap = 2'b10; addrStrap = 1'b0; oeN = 8'b0000_0101;
    expect_state(8'hFA, 2'b01, 2'b01, 7'b1101010, "R6");
    // R6 register disable, reference still runs
    regEn = 8'b0111_1111;
    expect_state(8'h7A, 2'b01, 2'b01, 7'b1101010, "R6");
    // R4 R5 power-down: legs low, reference driven low
    pwrGood = 1'b0;
    expect_state('0, 2'b00, 2'b01, 7'b1101010, "R4_R5");
    // R9 exit with lock missing stays blocked, straps not relatched (R1)
    pllLock = 1'b0; pwrGood = 1'b1;
    expect_state('0, 2'b01, 2'b01, 7'b1101010, "R9_R1");
    // R8 lock returns, pairs resume
    pllLock = 1'b1;
    expect_state(8'h7A, 2'b01, 2'b01, 7'b1101010, "R8");
    // R2 code 11 -> -0.5%, R3 address low
    do_reset(2'b11, 1'b0);
    oeN = '0; regEn = '1;
    pwrGood = 1'b1;
    expect_state('0, 2'b01, 2'b10, 7'b1101000, "R8_R2");
    pllLock = 1'b1;
    expect_state(8'hFF, 2'b01, 2'b10, 7'b1101000, "R2_R3");
    // R2 code 00 -> no spread, code 10 -> -0.5%
    do_reset(2'b00, 1'b1);
    pwrGood = 1'b1; pllLock = 1'b1;
    expect_state(8'hFF, 2'b01, 2'b00, 7'b1101010, "R2");
    do_reset(2'b10, 1'b0);
    pwrGood = 1'b1; pllLock = 1'b1; oeN = 8'hF0;
    expect_state(8'h0F, 2'b01, 2'b10, 7'b1101000, "R2_R6");
    chk(runtHits == 0, "R10", "true leg rose from gated state", runtHits, 0);
    finish_run();
  end

endmodule